// File: doc/BRIEF.md
# DC-Mode Intra Block Predictor

This block builds the DC-mode intra prediction for one square block. The side is 4, 8, 16 or 32 samples. The caller presents the row of reference samples above the block, the column of reference samples to its left and a size code, all in one clock with a valid strobe.

The references that belong to the block are summed in a registered binary adder tree. The sum is rounded into an average, the DC value, which fills the block. For sides up to 16, the top-left sample, the rest of the top row and the rest of the left column are smoothed. Each of those samples is blended with the references next to it through small parallel filters. A per-position selector builds the output frame, which carries a valid flag.

The pipeline accepts a new block on every clock. The block sizes may change from one block to the next.

Top module: `dc_intra_pred`

## Requirements
- R1: A block accepted on a rising edge with `in_valid` high appears on `pred_blk`, with `out_valid` high, exactly 7 clock cycles later. `out_valid` is low in every cycle that does not carry a result.
- R2: Size codes map as follows: 0 is 4, 1 is 8, 2 is 16 and 3 is 32. Top reference x sits at `top_ref[8x+7:8x]` and left reference y sits at `left_ref[8y+7:8y]`. For a side N, let S be the sum of top references 0..N-1 and left references 0..N-1. Then dc = (S + N) >> (log2(N)+1). Every sample with x ≥ 1 and y ≥ 1 inside the block equals dc. References with index N or above have no effect.
- R3: For N ≤ 16, the sample at (0,0) equals (left[0] + 2·dc + top[0] + 2) >> 2.
- R4: For N ≤ 16, each top-row sample (x ≥ 1, y = 0) equals (top[x] + 3·dc + 2) >> 2.
- R5: For N ≤ 16, each left-column sample (x = 0, y ≥ 1) equals (left[y] + 3·dc + 2) >> 2.
- R6: For N = 32, every sample of the block, including the first row and the first column, equals dc.
- R7: Every sample of the 32×32 output frame with x ≥ N or y ≥ N is 0. Sample (y,x) sits at `pred_blk[8(32y+x)+7 : 8(32y+x)]`.
- R8: While reset is asserted, and after it is released until a block has passed through, `out_valid` is low.
- R9: Blocks of mixed sizes presented on consecutive cycles each produce their own correct result, in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the valid pipeline |
| in_valid | input | 1 | Block strobe |
| in_size | input | 2 | Block side code (0:4, 1:8, 2:16, 3:32) |
| top_ref | input | 256 | Above-row references, sample x at bits 8x+7:8x |
| left_ref | input | 256 | Left-column references, sample y at bits 8y+7:8y |
| out_valid | output | 1 | Predicted frame valid |
| pred_blk | output | 8192 | Predicted 32×32 frame, sample (y,x) at bits 8(32y+x)+7:8(32y+x) |

## Verification
Every result is due 7 cycles after the edge that accepted its block. There are six tree levels, one rounding stage and one output stage. The bench drives inputs on falling edges, so a block is taken on the next rising edge. It samples outputs on falling edges, and it confirms that `out_valid` is still low one cycle before the block is due and high when the block is due. When blocks are issued on consecutive cycles, the bench reads each result on the consecutive falling edges that follow the first due cycle and compares every region of the frame against its own model.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

   // Side length of a block from its size code.
   function automatic int side_of(input int min_side, input int code);
      return min_side << code;
   endfunction

   // Accumulator width able to hold the rounded sum of 2*max_side samples.
   function automatic int acc_need(input int sample_w, input int max_side);
      return sample_w + $clog2(2 * max_side);
   endfunction

endpackage

// File: rtl/dcp_adder_tree.sv
module dcp_adder_tree #(
   parameter int IN_W   = 8,
   parameter int ACC_W  = 14,
   parameter int LEAVES = 64,
   localparam int LEVELS = $clog2(LEAVES)
) (
   input  logic                   clk,
   input  logic [LEAVES*IN_W-1:0] leaves,
   output logic [ACC_W-1:0]       total
);

   if ((1 << LEVELS) != LEAVES) begin : g_bad_leaves
      $error("dcp_adder_tree: LEAVES must be a power of two");
   end

   for (genvar g = 0; g < LEVELS; g++) begin : lv
      localparam int CNT = LEAVES >> (g + 1);
      logic [ACC_W-1:0] q [CNT];
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            for (int i = 0; i < CNT; i++) begin
               q[i] <= ACC_W'(leaves[(2*i)*IN_W +: IN_W])
                     + ACC_W'(leaves[(2*i+1)*IN_W +: IN_W]);
            end
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            for (int i = 0; i < CNT; i++) begin
               q[i] <= lv[g-1].q[2*i] + lv[g-1].q[2*i+1];
            end
         end
      end
   end

   assign total = lv[LEVELS-1].q[0];

endmodule

// File: rtl/dcp_delay.sv
module dcp_delay #(
   parameter int W     = 8,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("dcp_delay: DEPTH must be at least 1");
   end

   logic [W-1:0] st [DEPTH];

   always_ff @(posedge clk) begin
      st[0] <= d;
      for (int j = 1; j < DEPTH; j++) begin
         st[j] <= st[j-1];
      end
   end

   assign q = st[DEPTH-1];

endmodule

// File: rtl/dcp_edge_filter.sv
module dcp_edge_filter #(
   parameter int SAMPLE_W = 8
) (
   input  logic [SAMPLE_W-1:0] ref_a,
   input  logic [SAMPLE_W-1:0] ref_b,
   input  logic [SAMPLE_W-1:0] dc,
   output logic [SAMPLE_W-1:0] smooth
);

   localparam int W2 = SAMPLE_W + 2;

   // (a + b + 2*dc + 2) / 4 : with b tied to dc this is the two-tap blend.
   assign smooth = SAMPLE_W'((W2'(ref_a) + W2'(ref_b) + (W2'(dc) << 1) + W2'(2)) >> 2);

endmodule

// File: rtl/dc_intra_pred.sv
module dc_intra_pred #(
   parameter int SAMPLE_W   = 8,
   parameter int MIN_N      = 4,
   parameter int MAX_N      = 32,
   parameter int FILT_MAX_N = 16,
   parameter int ACC_W      = 14,
   localparam int SZ_W = $clog2($clog2(MAX_N / MIN_N) + 1)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              in_valid,
   input  logic [SZ_W-1:0]                   in_size,
   input  logic [MAX_N*SAMPLE_W-1:0]         top_ref,
   input  logic [MAX_N*SAMPLE_W-1:0]         left_ref,
   output logic                              out_valid,
   output logic [MAX_N*MAX_N*SAMPLE_W-1:0]   pred_blk
);

   import dcp_pkg::*;

   localparam int LEAVES  = 2 * MAX_N;
   localparam int LEVELS  = $clog2(LEAVES);
   localparam int STAGES  = LEVELS + 2;
   localparam int MIN_LOG = $clog2(MIN_N);
   localparam int REF_W   = 2 * MAX_N * SAMPLE_W;

   if ((1 << $clog2(MAX_N)) != MAX_N || (1 << MIN_LOG) != MIN_N) begin : g_bad_pow2
      $error("dc_intra_pred: MIN_N and MAX_N must be powers of two");
   end
   if (MAX_N <= MIN_N) begin : g_bad_range
      $error("dc_intra_pred: MAX_N must exceed MIN_N");
   end
   if (ACC_W < acc_need(SAMPLE_W, MAX_N)) begin : g_bad_acc
      $error("dc_intra_pred: ACC_W too narrow for the rounded sum");
   end

   // ---------------- leaf masking ----------------
   int n_in;
   logic [REF_W-1:0] leaves;

   always_comb begin
      n_in = side_of(MIN_N, int'(in_size));
      for (int i = 0; i < MAX_N; i++) begin
         leaves[i*SAMPLE_W +: SAMPLE_W] =
            (i < n_in) ? top_ref[i*SAMPLE_W +: SAMPLE_W] : '0;
         leaves[(MAX_N+i)*SAMPLE_W +: SAMPLE_W] =
            (i < n_in) ? left_ref[i*SAMPLE_W +: SAMPLE_W] : '0;
      end
   end

   // ---------------- summation ----------------
   logic [ACC_W-1:0] tree_sum;

   dcp_adder_tree #(
      .IN_W   (SAMPLE_W),
      .ACC_W  (ACC_W),
      .LEAVES (LEAVES)
   ) u_tree (
      .clk    (clk),
      .leaves (leaves),
      .total  (tree_sum)
   );

   // ---------------- side-band alignment ----------------
   logic [SZ_W-1:0]  sz_mid;
   logic [REF_W-1:0] refs_d;

   dcp_delay #(.W(SZ_W), .DEPTH(STAGES-2)) u_size_dly (
      .clk (clk),
      .d   (in_size),
      .q   (sz_mid)
   );

   dcp_delay #(.W(REF_W), .DEPTH(STAGES-1)) u_ref_dly (
      .clk (clk),
      .d   ({left_ref, top_ref}),
      .q   (refs_d)
   );

   logic [STAGES-1:0] vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else begin
         vld_q <= {vld_q[STAGES-2:0], in_valid};
      end
   end

   assign out_valid = vld_q[STAGES-1];

   // ---------------- rounding stage ----------------
   logic [SAMPLE_W-1:0] dc_q;
   logic [SZ_W-1:0]     sz_out_q;

   always_ff @(posedge clk) begin
      dc_q     <= SAMPLE_W'((tree_sum + ACC_W'(side_of(MIN_N, int'(sz_mid))))
                            >> (MIN_LOG + 1 + int'(sz_mid)));
      sz_out_q <= sz_mid;
   end

   // ---------------- edge filters ----------------
   logic [SAMPLE_W-1:0] corner_f;
   logic [SAMPLE_W-1:0] row_f [1:MAX_N-1];
   logic [SAMPLE_W-1:0] col_f [1:MAX_N-1];

   dcp_edge_filter #(.SAMPLE_W(SAMPLE_W)) u_corner (
      .ref_a  (refs_d[MAX_N*SAMPLE_W +: SAMPLE_W]),
      .ref_b  (refs_d[0 +: SAMPLE_W]),
      .dc     (dc_q),
      .smooth (corner_f)
   );

   for (genvar k = 1; k < MAX_N; k++) begin : g_edges
      dcp_edge_filter #(.SAMPLE_W(SAMPLE_W)) u_row (
         .ref_a  (refs_d[k*SAMPLE_W +: SAMPLE_W]),
         .ref_b  (dc_q),
         .dc     (dc_q),
         .smooth (row_f[k])
      );
      dcp_edge_filter #(.SAMPLE_W(SAMPLE_W)) u_col (
         .ref_a  (refs_d[(MAX_N+k)*SAMPLE_W +: SAMPLE_W]),
         .ref_b  (dc_q),
         .dc     (dc_q),
         .smooth (col_f[k])
      );
   end

   // ---------------- positional select ----------------
   int   n_out;
   logic filt_on;

   always_comb begin
      n_out   = side_of(MIN_N, int'(sz_out_q));
      filt_on = (n_out <= FILT_MAX_N);
   end

   for (genvar y = 0; y < MAX_N; y++) begin : g_row
      for (genvar x = 0; x < MAX_N; x++) begin : g_col
         logic [SAMPLE_W-1:0] edge_v;
         logic [SAMPLE_W-1:0] q;

         if (y == 0 && x == 0) begin : g_c
            assign edge_v = corner_f;
         end else if (y == 0) begin : g_t
            assign edge_v = row_f[x];
         end else if (x == 0) begin : g_l
            assign edge_v = col_f[y];
         end else begin : g_i
            assign edge_v = dc_q;
         end

         always_ff @(posedge clk) begin
            if (x >= n_out || y >= n_out) begin
               q <= '0;
            end else if (filt_on) begin
               q <= edge_v;
            end else begin
               q <= dc_q;
            end
         end

         assign pred_blk[(y*MAX_N+x)*SAMPLE_W +: SAMPLE_W] = q;
      end
   end

endmodule

// File: rtl/dc_intra_pred_chk.sv
module dc_intra_pred_chk #(
   parameter int SAMPLE_W = 8,
   parameter int MIN_N    = 4,
   parameter int MAX_N    = 32,
   localparam int SZ_W = $clog2($clog2(MAX_N / MIN_N) + 1)
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            in_valid,
   input logic [SZ_W-1:0]                 in_size,
   input logic                            out_valid,
   input logic [MAX_N*MAX_N*SAMPLE_W-1:0] pred_blk
);

   localparam int STAGES = $clog2(2 * MAX_N) + 2;

   logic [STAGES-1:0] vq;
   logic [SZ_W-1:0]   sq [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vq <= '0;
         for (int j = 0; j < STAGES; j++) sq[j] <= '0;
      end else begin
         vq    <= {vq[STAGES-2:0], in_valid};
         sq[0] <= in_size;
         for (int j = 1; j < STAGES; j++) sq[j] <= sq[j-1];
      end
   end

   function automatic logic [SAMPLE_W-1:0] pix(input int y, input int x);
      return pred_blk[(y*MAX_N+x)*SAMPLE_W +: SAMPLE_W];
   endfunction

   int   n_chk;
   logic inner_same, all_same, out_zero;

   always_comb begin
      n_chk      = MIN_N << sq[STAGES-1];
      inner_same = 1'b1;
      all_same   = 1'b1;
      out_zero   = 1'b1;
      for (int y = 0; y < MAX_N; y++) begin
         for (int x = 0; x < MAX_N; x++) begin
            if (x >= n_chk || y >= n_chk) begin
               if (pix(y, x) != '0) out_zero = 1'b0;
            end else begin
               if (pix(y, x) != pix(0, 0)) all_same = 1'b0;
               if (x >= 1 && y >= 1 && pix(y, x) != pix(1, 1)) inner_same = 1'b0;
            end
         end
      end
   end

   assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == vq[STAGES-1]);

   assert_interior_dc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> inner_same);

   assert_uniform_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && n_chk == MAX_N) |-> all_same);

   assert_outside_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_zero);

endmodule

bind dc_intra_pred dc_intra_pred_chk #(
   .SAMPLE_W (SAMPLE_W),
   .MIN_N    (MIN_N),
   .MAX_N    (MAX_N)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_size   (in_size),
   .out_valid (out_valid),
   .pred_blk  (pred_blk)
);

// File: tb/dc_intra_pred_tb.sv
`timescale 1ns/1ps
module dc_intra_pred_tb;

   localparam int W    = 8;
   localparam int MAXN = 32;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    in_valid = 1'b0;
   logic [1:0]              in_size = '0;
   logic [MAXN*W-1:0]       top_ref = '0;
   logic [MAXN*W-1:0]       left_ref = '0;
   logic                    out_valid;
   logic [MAXN*MAXN*W-1:0]  pred_blk;

   int checks = 0;
   int failures = 0;

   int cur_t [MAXN];
   int cur_l [MAXN];
   int cur_s;
   int q_t [4][MAXN];
   int q_l [4][MAXN];
   int q_s [4];

   always #2.5 clk = ~clk;

   dc_intra_pred u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_size   (in_size),
      .top_ref   (top_ref),
      .left_ref  (left_ref),
      .out_valid (out_valid),
      .pred_blk  (pred_blk)
   );

   task automatic chk(input string req, input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   function automatic int exp_dc();
      int n = 4 << cur_s;
      int sum = 0;
      for (int i = 0; i < n; i++) sum += cur_t[i] + cur_l[i];
      return (sum + n) >> (cur_s + 3);
   endfunction

   function automatic int exp_px(input int y, input int x);
      int n  = 4 << cur_s;
      int dc = exp_dc();
      if (x >= n || y >= n) return 0;
      if (n == 32) return dc;
      if (x == 0 && y == 0) return (cur_l[0] + 2*dc + cur_t[0] + 2) >> 2;
      if (y == 0) return (cur_t[x] + 3*dc + 2) >> 2;
      if (x == 0) return (cur_l[y] + 3*dc + 2) >> 2;
      return dc;
   endfunction

   task automatic drive_cur();
      in_size = 2'(cur_s);
      for (int i = 0; i < MAXN; i++) begin
         top_ref[i*W +: W]  = W'(cur_t[i]);
         left_ref[i*W +: W] = W'(cur_l[i]);
      end
   endtask

   // Compares the whole frame; one check per region class present.
   task automatic check_block(input string tag);
      string names [6] = '{"R2", "R3", "R4", "R5", "R6", "R7"};
      int seen [6];
      int bad  [6];
      int g1   [6];
      int e1   [6];
      int n = 4 << cur_s;
      for (int c = 0; c < 6; c++) begin seen[c] = 0; bad[c] = 0; g1[c] = 0; e1[c] = 0; end
      for (int y = 0; y < MAXN; y++) begin
         for (int x = 0; x < MAXN; x++) begin
            int c;
            int got = int'(pred_blk[(y*MAXN+x)*W +: W]);
            int e   = exp_px(y, x);
            if (x >= n || y >= n) c = 5;
            else if (n == 32)     c = 4;
            else if (x == 0 && y == 0) c = 1;
            else if (y == 0)      c = 2;
            else if (x == 0)      c = 3;
            else                  c = 0;
            seen[c] = 1;
            if (got != e) begin
               if (bad[c] == 0) begin g1[c] = got; e1[c] = e; end
               bad[c]++;
            end
         end
      end
      for (int c = 0; c < 6; c++) begin
         if (seen[c] != 0) begin
            checks++;
            if (bad[c] != 0) begin
               failures++;
               $display("FAIL %s %s: %0d samples wrong, first got %0d expected %0d",
                        names[c], tag, bad[c], g1[c], e1[c]);
            end
         end
      end
   endtask

   // Single block: due 7 cycles after the accepting edge (R1).
   task automatic send_one(input string tag);
      @(negedge clk);
      drive_cur();
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (6) @(negedge clk);
      chk("R1", {tag, " not yet valid"}, int'(out_valid), 0);
      @(negedge clk);
      chk("R1", {tag, " valid when due"}, int'(out_valid), 1);
      check_block(tag);
      @(negedge clk);
      chk("R1", {tag, " valid for one cycle"}, int'(out_valid), 0);
   endtask

   task automatic test_reset();
      repeat (3) @(negedge clk);
      chk("R8", "out_valid in reset", int'(out_valid), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R8", "out_valid after reset", int'(out_valid), 0);
   endtask

   task automatic test_random_sizes();
      for (int s = 0; s < 4; s++) begin
         cur_s = s;
         for (int i = 0; i < MAXN; i++) begin
            cur_t[i] = int'($urandom_range(0, 255));
            cur_l[i] = int'($urandom_range(0, 255));
         end
         send_one($sformatf("random size code %0d", s));
      end
   endtask

   task automatic test_extremes();
      cur_s = 3;
      for (int i = 0; i < MAXN; i++) begin cur_t[i] = 255; cur_l[i] = 255; end
      send_one("all-255 side 32 (R6)");
      cur_s = 0;
      send_one("all-255 side 4");
      cur_s = 2;
      for (int i = 0; i < MAXN; i++) begin cur_t[i] = 0; cur_l[i] = 0; end
      send_one("all-zero side 16");
      cur_s = 1;
      for (int i = 0; i < MAXN; i++) begin cur_t[i] = 255; cur_l[i] = 0; end
      send_one("top bright left dark side 8");
   endtask

   task automatic test_rounding();
      cur_s = 0;
      for (int i = 0; i < MAXN; i++) begin cur_t[i] = 0; cur_l[i] = 0; end
      cur_t[3] = 4;
      send_one("half rounds up side 4");
      chk("R2", "dc of sum 4 at side 4", int'(pred_blk[(1*MAXN+1)*W +: W]), 1);
      cur_t[3] = 3;
      send_one("below half rounds down side 4");
      chk("R2", "dc of sum 3 at side 4", int'(pred_blk[(1*MAXN+1)*W +: W]), 0);
   endtask

   task automatic test_ignore_beyond();
      cur_s = 1;
      for (int i = 0; i < MAXN; i++) begin
         cur_t[i] = (i < 8) ? 10 : 255;
         cur_l[i] = (i < 8) ? 10 : 255;
      end
      send_one("refs beyond side 8 ignored");
      chk("R2", "dc unaffected by refs beyond side", int'(pred_blk[(3*MAXN+5)*W +: W]), 10);
      chk("R7", "sample (8,8) outside side 8", int'(pred_blk[(8*MAXN+8)*W +: W]), 0);
   endtask

   task automatic test_back_to_back();
      int sizes [4] = '{3, 0, 2, 1};
      for (int b = 0; b < 4; b++) begin
         q_s[b] = sizes[b];
         for (int i = 0; i < MAXN; i++) begin
            q_t[b][i] = int'($urandom_range(0, 255));
            q_l[b][i] = int'($urandom_range(0, 255));
         end
      end
      @(negedge clk);
      for (int b = 0; b < 4; b++) begin
         cur_s = q_s[b];
         for (int i = 0; i < MAXN; i++) begin cur_t[i] = q_t[b][i]; cur_l[i] = q_l[b][i]; end
         drive_cur();
         in_valid = 1'b1;
         @(negedge clk);
      end
      in_valid = 1'b0;
      repeat (4) @(negedge clk);
      for (int b = 0; b < 4; b++) begin
         cur_s = q_s[b];
         for (int i = 0; i < MAXN; i++) begin cur_t[i] = q_t[b][i]; cur_l[i] = q_l[b][i]; end
         chk("R9", $sformatf("back-to-back block %0d valid", b), int'(out_valid), 1);
         check_block($sformatf("R9 back-to-back block %0d", b));
         @(negedge clk);
      end
      chk("R9", "valid drops after burst", int'(out_valid), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      test_reset();
      test_random_sizes();
      test_extremes();
      test_rounding();
      test_ignore_beyond();
      test_back_to_back();
      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule